// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Predictor

This block sits beside the fetch stage of a pipelined core. Each cycle the fetch address is looked up in a small direct-mapped table. The table is indexed by the PC bits just above the instruction-alignment bits. Each entry is matched against the full stored branch address. When the entry matches and its two-bit saturating counter leans towards taken, the block supplies the stored target as the next fetch address. Otherwise it supplies the sequential address. The lookup is purely combinational, so a correct prediction costs no cycles.

A later pipeline stage resolves each control-transfer instruction. It reports the address, whether it is an unconditional jump, the real direction and the real target. It also returns the prediction that fetch made for that instruction. From this report the block decides whether fetch went the wrong way. If so, it raises a flush request together with the address at which fetch must restart. On the same clock edge it trains the table: it allocates an entry for a newly seen taken transfer, re-targets an existing one, and moves the counter one step. Table writes take effect at the clock edge, so a lookup in the same cycle as an update still sees the old contents.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: any lookup gives lk_hit=0, lk_taken=0 and lk_next_pc = lk_pc + PC_STEP.
- R2: The entry is selected by lk_pc[IDX_LSB +: IDX_W], where IDX_LSB = log2(PC_STEP) and IDX_W = log2(DEPTH). A hit requires the full stored address to equal lk_pc, so an address that aliases to the same index misses.
- R3: The lookup acts in the same cycle. lk_taken is 1 only on a hit whose counter is 2 or 3. lk_next_pc is the stored target when lk_taken=1 and lk_pc + PC_STEP otherwise.
- R4: The counter saturates in the range 0 to 3. A resolved taken outcome on a matching entry adds one, up to 3. A not-taken outcome subtracts one, down to 0.
- R5: A resolved taken transfer with no matching entry writes its index with valid=1, its address, its target and counter 2 (weakly taken). A lookup of that address in the next cycle hits and predicts taken.
- R6: A resolved not-taken branch with no matching entry leaves the table unchanged.
- R7: flush_req=1 when rs_valid=1 and the real direction differs from rs_pred_taken, or when the transfer is taken and rs_pred_target differs from rs_target. restart_pc is rs_target when taken and rs_pc + PC_STEP when not taken.
- R8: When the fetch prediction matched the real direction, and matched the real target if taken, flush_req stays 0.
- R9: rs_is_jump=1 makes the outcome taken whatever rs_taken holds.
- R10: A taken outcome on a matching entry replaces the stored target with rs_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Matching valid entry found |
| lk_taken | output | 1 | Entry predicts taken |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | Resolution report present this cycle |
| rs_pc | input | PC_W | Address of the resolved transfer |
| rs_is_jump | input | 1 | Transfer is unconditional |
| rs_taken | input | 1 | Real branch direction |
| rs_target | input | PC_W | Real target address |
| rs_pred_taken | input | 1 | Direction predicted at fetch for this transfer |
| rs_pred_target | input | PC_W | Target predicted at fetch for this transfer |
| flush_req | output | 1 | Misprediction: flush younger instructions |
| restart_pc | output | PC_W | Address at which fetch restarts |

## Verification
One branch is driven through a full walk of its counter. The walk uses runs of taken and not-taken outcomes past both saturation points. The sequence of predictions that follows shows a true saturating counter apart from a wrapping counter or a one-bit history. Two addresses that share an index show full-address matching apart from index-only matching. A not-taken report for an unseen branch shows that no-allocate apart from always-allocate. A jump reported with rs_taken=0 and a re-targeted jump separate the direction error, the target error and the correct prediction in the flush and restart outputs.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN        = 2'd0;
  localparam ctr_t CTR_MAX        = 2'd3;
  localparam ctr_t CTR_WEAK_TAKEN = 2'd2;

  // One saturating step of the direction counter.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t res;
    if (up) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return res;
  endfunction

  // Upper half of the counter range means "taken".
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr,
  // fetch read port
  input  logic [IDX_W-1:0] fa_idx,
  output logic             fa_valid,
  output logic [PC_W-1:0]  fa_tag,
  output logic [PC_W-1:0]  fa_tgt,
  output ctr_t             fa_ctr,
  // resolve read port
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [PC_W-1:0]  rb_tag,
  output logic [PC_W-1:0]  rb_tgt,
  output ctr_t             rb_ctr
);

  logic             valid_q [DEPTH];
  logic [PC_W-1:0]  tag_q   [DEPTH];
  logic [PC_W-1:0]  tgt_q   [DEPTH];
  ctr_t             ctr_q   [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic            sel;
    logic            valid_d;
    logic [PC_W-1:0] tag_d;
    logic [PC_W-1:0] tgt_d;
    ctr_t            ctr_d;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    // next state
    always_comb begin
      valid_d = valid_q[e];
      tag_d   = tag_q[e];
      tgt_d   = tgt_q[e];
      ctr_d   = ctr_q[e];
      if (sel) begin
        valid_d = 1'b1;
        tag_d   = wr_tag;
        tgt_d   = wr_tgt;
        ctr_d   = wr_ctr;
      end
    end

    // valid bit: the only state that needs reset
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) valid_q[e] <= 1'b0;
      else             valid_q[e] <= valid_d;
    end

    // payload: enable-gated, no reset
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= tag_d;
        tgt_q[e] <= tgt_d;
        ctr_q[e] <= ctr_d;
      end
    end
  end

  always_comb begin
    fa_valid = valid_q[fa_idx];
    fa_tag   = tag_q[fa_idx];
    fa_tgt   = tgt_q[fa_idx];
    fa_ctr   = ctr_q[fa_idx];
    rb_valid = valid_q[rb_idx];
    rb_tag   = tag_q[rb_idx];
    rb_tgt   = tgt_q[rb_idx];
    rb_ctr   = ctr_q[rb_idx];
  end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_is_jump,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_pred_taken,
  input  logic [PC_W-1:0] rs_pred_target,
  // current content of the indexed entry
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [PC_W-1:0] ent_tgt,
  input  ctr_t            ent_ctr,
  // training write
  output logic            wr_en,
  output logic [PC_W-1:0] wr_tag,
  output logic [PC_W-1:0] wr_tgt,
  output ctr_t            wr_ctr,
  // redirect
  output logic            flush_req,
  output logic [PC_W-1:0] restart_pc
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  logic actual_taken;
  logic ent_match;
  logic dir_wrong;
  logic tgt_wrong;

  always_comb begin
    actual_taken = rs_taken || rs_is_jump;
    ent_match    = ent_valid && (ent_tag == rs_pc);

    // training: allocate on unseen taken, update on any match
    wr_en  = rs_valid && (actual_taken || ent_match);
    wr_tag = rs_pc;
    wr_tgt = actual_taken ? rs_target : ent_tgt;
    wr_ctr = ent_match ? ctr_step(ent_ctr, actual_taken) : CTR_WEAK_TAKEN;

    // misprediction detection
    dir_wrong  = actual_taken != rs_pred_taken;
    tgt_wrong  = actual_taken && (rs_pred_target != rs_target);
    flush_req  = rs_valid && (dir_wrong || tgt_wrong);
    restart_pc = actual_taken ? rs_target : rs_pc + STEP_V;
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DEPTH   = 16,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_is_jump,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_pred_taken,
  input  logic [PC_W-1:0] rs_pred_target,
  output logic            flush_req,
  output logic [PC_W-1:0] restart_pc
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int IDX_LSB = $clog2(PC_STEP);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  logic             rst_sync_n;

  logic [IDX_W-1:0] fa_idx;
  logic             fa_valid;
  logic [PC_W-1:0]  fa_tag;
  logic [PC_W-1:0]  fa_tgt;
  ctr_t             fa_ctr;

  logic [IDX_W-1:0] rb_idx;
  logic             rb_valid;
  logic [PC_W-1:0]  rb_tag;
  logic [PC_W-1:0]  rb_tgt;
  ctr_t             rb_ctr;

  logic             wr_en;
  logic [PC_W-1:0]  wr_tag;
  logic [PC_W-1:0]  wr_tgt;
  ctr_t             wr_ctr;

  btb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign fa_idx = lk_pc[IDX_LSB +: IDX_W];
  assign rb_idx = rs_pc[IDX_LSB +: IDX_W];

  btb_store #(.PC_W(PC_W), .DEPTH(DEPTH)) i_store (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .wr_en      (wr_en),
    .wr_idx     (rb_idx),
    .wr_tag     (wr_tag),
    .wr_tgt     (wr_tgt),
    .wr_ctr     (wr_ctr),
    .fa_idx     (fa_idx),
    .fa_valid   (fa_valid),
    .fa_tag     (fa_tag),
    .fa_tgt     (fa_tgt),
    .fa_ctr     (fa_ctr),
    .rb_idx     (rb_idx),
    .rb_valid   (rb_valid),
    .rb_tag     (rb_tag),
    .rb_tgt     (rb_tgt),
    .rb_ctr     (rb_ctr)
  );

  btb_resolve #(.PC_W(PC_W), .PC_STEP(PC_STEP)) i_resolve (
    .rs_valid       (rs_valid),
    .rs_pc          (rs_pc),
    .rs_is_jump     (rs_is_jump),
    .rs_taken       (rs_taken),
    .rs_target      (rs_target),
    .rs_pred_taken  (rs_pred_taken),
    .rs_pred_target (rs_pred_target),
    .ent_valid      (rb_valid),
    .ent_tag        (rb_tag),
    .ent_tgt        (rb_tgt),
    .ent_ctr        (rb_ctr),
    .wr_en          (wr_en),
    .wr_tag         (wr_tag),
    .wr_tgt         (wr_tgt),
    .wr_ctr         (wr_ctr),
    .flush_req      (flush_req),
    .restart_pc     (restart_pc)
  );

  // fetch-side prediction, same cycle
  always_comb begin
    lk_hit     = fa_valid && (fa_tag == lk_pc);
    lk_taken   = lk_hit && ctr_says_taken(fa_ctr);
    lk_next_pc = lk_taken ? fa_tgt : lk_pc + STEP_V;
  end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_next_pc,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_is_jump,
  input logic            rs_taken,
  input logic [PC_W-1:0] rs_target,
  input logic            rs_pred_taken,
  input logic [PC_W-1:0] rs_pred_target,
  input logic            flush_req,
  input logic [PC_W-1:0] restart_pc
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  AST_TAKEN_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_taken |-> lk_hit); // R3

  AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_taken |-> (lk_next_pc == lk_pc + STEP_V)); // R3

  AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_valid && (rs_taken || rs_is_jump)) |=> ((lk_pc != $past(rs_pc)) || lk_hit)); // R5

  AST_FLUSH_NEEDS_REPORT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_req |-> rs_valid); // R7

  AST_NT_RESTART_SEQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_req && !rs_taken && !rs_is_jump) |-> (restart_pc == rs_pc + STEP_V)); // R7

  AST_JUMP_RESTART_TGT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_req && rs_is_jump) |-> (restart_pc == rs_target)); // R9

  AST_CORRECT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_valid && ((rs_taken || rs_is_jump) == rs_pred_taken)
     && (!rs_pred_taken || rs_pred_target == rs_target)) |-> !flush_req); // R8

endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W), .PC_STEP(PC_STEP)) i_btb_checker (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .lk_pc          (lk_pc),
  .lk_hit         (lk_hit),
  .lk_taken       (lk_taken),
  .lk_next_pc     (lk_next_pc),
  .rs_valid       (rs_valid),
  .rs_pc          (rs_pc),
  .rs_is_jump     (rs_is_jump),
  .rs_taken       (rs_taken),
  .rs_target      (rs_target),
  .rs_pred_taken  (rs_pred_taken),
  .rs_pred_target (rs_pred_target),
  .flush_req      (flush_req),
  .restart_pc     (restart_pc)
);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;

  localparam int PC_W = 32;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_hit;
  logic            lk_taken;
  logic [PC_W-1:0] lk_next_pc;
  logic            rs_valid;
  logic [PC_W-1:0] rs_pc;
  logic            rs_is_jump;
  logic            rs_taken;
  logic [PC_W-1:0] rs_target;
  logic            rs_pred_taken;
  logic [PC_W-1:0] rs_pred_target;
  logic            flush_req;
  logic [PC_W-1:0] restart_pc;

  int n_run;
  int n_fail;
  bit done;

  btb_predictor #(.PC_W(PC_W), .DEPTH(16), .PC_STEP(4)) i_btb_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_jump(rs_is_jump), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
    .flush_req(flush_req), .restart_pc(restart_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [PC_W-1:0] act,
                     input logic [PC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Lookup in a quiet cycle and check all three outputs.
  task automatic lookup(input string req, input logic [PC_W-1:0] pc, input logic e_hit,
                        input logic e_tk, input logic [PC_W-1:0] e_next);
    @(negedge clk);
    lk_pc = pc;
    #2;
    chk(req, "lk_hit", PC_W'(lk_hit), PC_W'(e_hit));
    chk(req, "lk_taken", PC_W'(lk_taken), PC_W'(e_tk));
    chk(req, "lk_next_pc", lk_next_pc, e_next);
  endtask

  // Present one resolution report for one cycle and check the redirect outputs.
  task automatic resolve(input string req, input logic [PC_W-1:0] pc, input logic jmp,
                         input logic tk, input logic [PC_W-1:0] tgt, input logic ptk,
                         input logic [PC_W-1:0] ptgt, input logic e_flush,
                         input logic [PC_W-1:0] e_restart);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_is_jump = jmp; rs_taken = tk;
    rs_target = tgt; rs_pred_taken = ptk; rs_pred_target = ptgt;
    #2;
    chk(req, "flush_req", PC_W'(flush_req), PC_W'(e_flush));
    if (e_flush) chk(req, "restart_pc", restart_pc, e_restart);
    @(posedge clk);
    #1 rs_valid = 1'b0;
  endtask

  task automatic t_reset;
    lookup("R1", 32'h100, 1'b0, 1'b0, 32'h104);
    lookup("R1", 32'h2c, 1'b0, 1'b0, 32'h30);
  endtask

  task automatic t_alloc;
    // unseen taken branch: direction mispredicted, restart at target
    resolve("R7", 32'h100, 1'b0, 1'b1, 32'h200, 1'b0, 32'h0, 1'b1, 32'h200);
    lookup("R5", 32'h100, 1'b1, 1'b1, 32'h200);
    // correct taken prediction: no flush
    resolve("R8", 32'h100, 1'b0, 1'b1, 32'h200, 1'b1, 32'h200, 1'b0, 32'h0);
  endtask

  task automatic t_counter;
    // counter now 3; another taken keeps it at 3
    resolve("R4", 32'h100, 1'b0, 1'b1, 32'h200, 1'b1, 32'h200, 1'b0, 32'h0);
    // one not-taken: 3 -> 2, still taken; restart after the branch
    resolve("R7", 32'h100, 1'b0, 1'b0, 32'h200, 1'b1, 32'h200, 1'b1, 32'h104);
    lookup("R4", 32'h100, 1'b1, 1'b1, 32'h200);
    resolve("R4", 32'h100, 1'b0, 1'b0, 32'h200, 1'b1, 32'h200, 1'b1, 32'h104);
    lookup("R4", 32'h100, 1'b1, 1'b0, 32'h104);
    // predicted not-taken and not taken: correct, no flush (1 -> 0)
    resolve("R8", 32'h100, 1'b0, 1'b0, 32'h200, 1'b0, 32'h0, 1'b0, 32'h0);
    resolve("R4", 32'h100, 1'b0, 1'b0, 32'h200, 1'b0, 32'h0, 1'b0, 32'h0);
    // floor held at 0: one taken gives 1, still not taken
    resolve("R7", 32'h100, 1'b0, 1'b1, 32'h200, 1'b0, 32'h0, 1'b1, 32'h200);
    lookup("R4", 32'h100, 1'b1, 1'b0, 32'h104);
    resolve("R4", 32'h100, 1'b0, 1'b1, 32'h200, 1'b0, 32'h0, 1'b1, 32'h200);
    lookup("R4", 32'h100, 1'b1, 1'b1, 32'h200);
  endtask

  task automatic t_alias_noalloc;
    // 0x140 shares index 0 with 0x100
    lookup("R2", 32'h140, 1'b0, 1'b0, 32'h144);
    // not-taken unseen branch: no flush, no allocation
    resolve("R6", 32'h304, 1'b0, 1'b0, 32'h800, 1'b0, 32'h0, 1'b0, 32'h0);
    lookup("R6", 32'h304, 1'b0, 1'b0, 32'h308);
    // aliasing taken branch replaces the entry
    resolve("R5", 32'h140, 1'b0, 1'b1, 32'h600, 1'b0, 32'h0, 1'b1, 32'h600);
    lookup("R2", 32'h140, 1'b1, 1'b1, 32'h600);
    lookup("R2", 32'h100, 1'b0, 1'b0, 32'h104);
  endtask

  task automatic t_jump;
    // jump with rs_taken low still counts as taken
    resolve("R9", 32'h208, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0, 1'b1, 32'h400);
    lookup("R9", 32'h208, 1'b1, 1'b1, 32'h400);
    // right direction, wrong target: flush, and the target is replaced
    resolve("R10", 32'h208, 1'b1, 1'b0, 32'h500, 1'b1, 32'h400, 1'b1, 32'h500);
    lookup("R10", 32'h208, 1'b1, 1'b1, 32'h500);
  endtask

  initial begin
    done = 1'b0;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0;
    lk_pc = '0; rs_valid = 1'b0; rs_pc = '0; rs_is_jump = 1'b0; rs_taken = 1'b0;
    rs_target = '0; rs_pred_taken = 1'b0; rs_pred_target = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_alloc();
    t_counter();
    t_alias_noalloc();
    t_jump();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule